// File: doc/BRIEF.md
# Interrupt Source Bank with Directed and Distributed Routing

This block holds a bank of interrupt sources. Each source has a configuration word and a destination word. The configuration word holds a mask, an activity flag, a delivery mode, polarity, sense, a 4-bit priority and an 8-bit vector. The destination word holds two spare software bits and one enable bit per CPU. Input lines are sampled on the clock. Each input is qualified by the source's sense and polarity and gated by its mask, priority and destination. Each qualified event becomes a one-cycle raise strobe to one or more CPUs.

A source that fires sets its activity flag. While the flag is set, the source cannot raise again, and the fields that shape triggering are locked. A level-sensitive source clears its own flag when its line returns to the inactive level. Any source can also have its flag cleared from outside through `clrActive`, which is how the neighbouring acknowledge logic retires an interrupt. In directed mode every enabled CPU is raised. In distributed mode a single CPU is chosen round-robin, starting after the CPU served last.

Configuration words and destination words are written through a single-cycle write port. Either word can be read back combinationally for any source. Raise strobes leave on a flat vector; bit `cpu*NUM_SRC + src` is the strobe for that CPU and source.

Top module: `isrc_bank`

## Requirements
- R1: After reset every configuration word reads 0xA0000000 (masked, distributed mode), every destination word reads 0, and no raise strobe is set.
- R2: A configuration write keeps bit 31 (mask, 1 = masked), bit 29 (mode, 1 = distributed), bits 19:16 (priority) and bits 7:0 (vector). Bit 30 (activity) cannot be written, and the other bits read 0. A destination write keeps bits 31:30 and bits NUM_CPU-1:0 (CPU enables) and drops the rest.
- R3: Bit 23 (polarity, 1 = active low) and bit 22 (sense, 1 = level) are writable only on sources below NUM_EXT. On the other sources both read 0, which means edge-sensitive and active high.
- R4: A source that is masked, has priority 0, or has all CPU enable bits at 0 never raises, whatever its line does.
- R5: A level source raises while its effective input is asserted and its activity bit is clear. Raising sets activity, which reads back at bit 30. When the effective input deasserts, activity clears and a later assertion raises again.
- R6: An edge source raises only on a 0-to-1 transition of its registered effective input. A line held high after its activity is cleared does not raise again.
- R7: An asserted input on a source whose activity bit is set produces no raise.
- R8: In directed mode, or when the CPU enables name only the CPU served last, all enabled CPUs are raised in the same cycle.
- R9: In distributed mode exactly one CPU is raised. It is the first enabled CPU found searching upward from the one after the CPU served last, wrapping around. That CPU becomes the one served last; after reset the CPU served last is CPU 0.
- R10: While a source's activity bit is set, a configuration write may change only the mask, priority and vector. Mode, sense and polarity keep their values.
- R11: A pulse on `clrActive[s]` clears the activity bit of source s by the next cycle.
- R12: A raise strobe appears on the second rising edge after the input line changes, one register for sampling and one for the output. It lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | NUM_SRC | Raw interrupt input lines |
| clrActive | input | NUM_SRC | Per-source activity clear from the acknowledge logic |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | 0 = configuration word, 1 = destination word |
| wrIdx | input | IDXW | Source index being written |
| wrData | input | 32 | Write data |
| rdIdx | input | IDXW | Source index being read |
| rdCfg | output | 32 | Configuration word of source rdIdx |
| rdDest | output | 32 | Destination word of source rdIdx |
| raiseReq | output | NUM_CPU*NUM_SRC | Raise strobes, bit cpu*NUM_SRC+src |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Each of the three gating conditions is held alone while the line is high. A design that ignored any one of them would send a strobe.
- A held-high line is checked on an active source and on an edge source whose activity was just cleared. A design that retriggered on level would repeat raises.
- A configuration write is made while the source is active. A design that did not lock the trigger fields would show changed sense, polarity or mode on readback.
- Distributed delivery is stepped through several raises, including a single-CPU mask equal to the CPU served last. An off-by-one in the rotation would show up as the wrong CPU or as two CPUs raised.

// File: rtl/isrc_pkg.sv
`timescale 1ns/1ps
package isrc_pkg;
  localparam int MASK_BIT  = 31;
  localparam int ACT_BIT   = 30;
  localparam int MODE_BIT  = 29;
  localparam int POL_BIT   = 23;
  localparam int SENSE_BIT = 22;
  localparam int PRIO_LO   = 16;
  localparam int PRIO_W    = 4;
  localparam int VEC_W     = 8;

  typedef enum logic {
    SEL_CFG  = 1'b0,
    SEL_DEST = 1'b1
  } wrSel_e;

  // control -> datapath strobes, one per source
  typedef struct packed {
    logic setAct;
    logic clrAct;
    logic updLast;
  } srcStrobe_t;
endpackage

// File: rtl/isrc_regbank.sv
`timescale 1ns/1ps
module isrc_regbank import isrc_pkg::*; #(
  parameter int NUM_SRC = 16,
  parameter int NUM_CPU = 2,
  parameter int NUM_EXT = 12,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPUW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic                              wrSel,
  input  logic [IDXW-1:0]                   wrIdx,
  input  logic [31:0]                       wrData,
  input  srcStrobe_t [NUM_SRC-1:0]          strobe,
  input  logic [NUM_SRC-1:0][CPUW-1:0]      newLast,
  input  logic [IDXW-1:0]                   rdIdx,
  output logic [NUM_SRC-1:0]                maskQ,
  output logic [NUM_SRC-1:0]                modeQ,
  output logic [NUM_SRC-1:0]                polQ,
  output logic [NUM_SRC-1:0]                senseQ,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prioQ,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   destCpu,
  output logic [NUM_SRC-1:0]                actQ,
  output logic [NUM_SRC-1:0][CPUW-1:0]      lastQ,
  output logic [31:0]                       rdCfg,
  output logic [31:0]                       rdDest
);
  logic [NUM_SRC-1:0][31:0] cfgWord;
  logic [NUM_SRC-1:0][31:0] destWord;
  logic unusedWr;

  assign unusedWr = ^{wrData[28:24], wrData[21:20], wrData[15:8], wrData[29:NUM_CPU]};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam bit IS_EXT = (s < NUM_EXT);
    logic             maskR, modeR, polR, senseR, actR;
    logic [PRIO_W-1:0] prioR;
    logic [VEC_W-1:0]  vecR;
    logic [1:0]        destHiR;
    logic [NUM_CPU-1:0] destR;
    logic [CPUW-1:0]   lastR;
    logic              cfgHit, destHit;

    assign cfgHit  = wrEn && (wrSel == SEL_CFG)  && (wrIdx == IDXW'(s));
    assign destHit = wrEn && (wrSel == SEL_DEST) && (wrIdx == IDXW'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskR   <= 1'b1;
        modeR   <= 1'b1;
        polR    <= 1'b0;
        senseR  <= 1'b0;
        prioR   <= '0;
        vecR    <= '0;
        destHiR <= '0;
        destR   <= '0;
        actR    <= 1'b0;
        lastR   <= '0;
      end else begin
        if (cfgHit) begin
          maskR <= wrData[MASK_BIT];
          prioR <= wrData[PRIO_LO +: PRIO_W];
          vecR  <= wrData[VEC_W-1:0];
          if (!actR) begin
            modeR <= wrData[MODE_BIT];
            if (IS_EXT) begin
              polR   <= wrData[POL_BIT];
              senseR <= wrData[SENSE_BIT];
            end
          end
        end
        if (destHit) begin
          destHiR <= wrData[31:30];
          destR   <= wrData[NUM_CPU-1:0];
        end
        actR <= (actR & ~strobe[s].clrAct) | strobe[s].setAct;
        if (strobe[s].updLast) lastR <= newLast[s];
      end
    end

    assign maskQ[s]   = maskR;
    assign modeQ[s]   = modeR;
    assign polQ[s]    = polR;
    assign senseQ[s]  = senseR;
    assign prioQ[s]   = prioR;
    assign destCpu[s] = destR;
    assign actQ[s]    = actR;
    assign lastQ[s]   = lastR;

    assign cfgWord[s]  = {maskR, actR, modeR, 5'b0, polR, senseR, 2'b0,
                          prioR, 8'b0, vecR};
    assign destWord[s] = {destHiR, {(30-NUM_CPU){1'b0}}, destR};

    AST_TRIG_LOCK: assert property (@(posedge clk) disable iff (!rstN)
      $past(actR && cfgHit) |-> (modeR == $past(modeR)) && (polR == $past(polR))
                                && (senseR == $past(senseR)))
      else $error("trigger fields changed while active"); // R10

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe[s].clrAct && !strobe[s].setAct) |-> !actR)
      else $error("activity survived a clear"); // R11
  end

  assign rdCfg  = cfgWord[rdIdx];
  assign rdDest = destWord[rdIdx];
endmodule

// File: rtl/isrc_router.sv
`timescale 1ns/1ps
module isrc_router import isrc_pkg::*; #(
  parameter int NUM_SRC = 16,
  parameter int NUM_CPU = 2,
  localparam int CPUW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0]                srcLevel,
  input  logic [NUM_SRC-1:0]                clrActive,
  input  logic [NUM_SRC-1:0]                maskQ,
  input  logic [NUM_SRC-1:0]                modeQ,
  input  logic [NUM_SRC-1:0]                polQ,
  input  logic [NUM_SRC-1:0]                senseQ,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]    prioQ,
  input  logic [NUM_SRC-1:0][NUM_CPU-1:0]   destCpu,
  input  logic [NUM_SRC-1:0]                actQ,
  input  logic [NUM_SRC-1:0][CPUW-1:0]      lastQ,
  output srcStrobe_t [NUM_SRC-1:0]          strobe,
  output logic [NUM_SRC-1:0][CPUW-1:0]      newLast,
  output logic [NUM_CPU*NUM_SRC-1:0]        raiseReq
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic               lvlR, effPrevR;
    logic               eff, eligible, trig, fire, lowClr, directed;
    logic [CPUW-1:0]    rrPick;
    logic               rrHit;
    logic [NUM_CPU-1:0] target, rowR;

    assign eff      = lvlR ^ polQ[s];
    assign eligible = !maskQ[s] && (prioQ[s] != '0) && (|destCpu[s]);
    assign trig     = senseQ[s] ? eff : (eff && !effPrevR);
    assign fire     = eligible && trig && !actQ[s];
    assign lowClr   = eligible && senseQ[s] && !eff && actQ[s];
    assign directed = !modeQ[s] || (destCpu[s] == (NUM_CPU'(1) << lastQ[s]));

    always_comb begin
      rrPick = lastQ[s];
      rrHit  = 1'b0;
      for (int k = 1; k <= NUM_CPU; k++) begin
        int c;
        c = (int'(lastQ[s]) + k) % NUM_CPU;
        if (!rrHit && destCpu[s][c]) begin
          rrPick = CPUW'(c);
          rrHit  = 1'b1;
        end
      end
    end

    assign target = directed ? destCpu[s] : (NUM_CPU'(1) << rrPick);

    assign strobe[s].setAct  = fire;
    assign strobe[s].clrAct  = lowClr || clrActive[s];
    assign strobe[s].updLast = fire && !directed;
    assign newLast[s]        = rrPick;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvlR     <= 1'b0;
        effPrevR <= 1'b0;
        rowR     <= '0;
      end else begin
        lvlR     <= srcLevel[s];
        effPrevR <= eff;
        rowR     <= fire ? target : '0;
      end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign raiseReq[c*NUM_SRC + s] = rowR[c];
    end

    AST_RAISE_GATED: assert property (@(posedge clk) disable iff (!rstN)
      (|rowR) |-> $past(!maskQ[s] && (prioQ[s] != '0) && (|destCpu[s])))
      else $error("raise from a gated source"); // R4

    AST_RAISE_MARKS_ACT: assert property (@(posedge clk) disable iff (!rstN)
      (|rowR) |-> actQ[s])
      else $error("raise without activity"); // R5

    AST_NO_RAISE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
      (|rowR) |-> $past(!actQ[s]))
      else $error("raise while already active"); // R7

    AST_ROW_IN_DEST: assert property (@(posedge clk) disable iff (!rstN)
      (|rowR) |-> ((rowR & ~$past(destCpu[s])) == '0))
      else $error("raise outside destination"); // R8

    AST_DIST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      ((|rowR) && $past(modeQ[s] && (destCpu[s] != (NUM_CPU'(1) << lastQ[s]))))
        |-> ($countones(rowR) == 1))
      else $error("distributed raise hit several CPUs"); // R9
  end
endmodule

// File: rtl/isrc_bank.sv
`timescale 1ns/1ps
module isrc_bank import isrc_pkg::*; #(
  parameter int NUM_SRC = 16,
  parameter int NUM_CPU = 2,
  parameter int NUM_EXT = 12,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPUW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  logic [NUM_SRC-1:0]         clrActive,
  input  logic                       wrEn,
  input  logic                       wrSel,
  input  logic [IDXW-1:0]            wrIdx,
  input  logic [31:0]                wrData,
  input  logic [IDXW-1:0]            rdIdx,
  output logic [31:0]                rdCfg,
  output logic [31:0]                rdDest,
  output logic [NUM_CPU*NUM_SRC-1:0] raiseReq
);
  logic [NUM_SRC-1:0]              maskQ, modeQ, polQ, senseQ, actQ;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prioQ;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] destCpu;
  logic [NUM_SRC-1:0][CPUW-1:0]    lastQ, newLast;
  srcStrobe_t [NUM_SRC-1:0]        strobe;

  isrc_regbank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_EXT(NUM_EXT)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .strobe(strobe), .newLast(newLast), .rdIdx(rdIdx),
    .maskQ(maskQ), .modeQ(modeQ), .polQ(polQ), .senseQ(senseQ),
    .prioQ(prioQ), .destCpu(destCpu), .actQ(actQ), .lastQ(lastQ),
    .rdCfg(rdCfg), .rdDest(rdDest)
  );

  isrc_router #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) route_i (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .clrActive(clrActive),
    .maskQ(maskQ), .modeQ(modeQ), .polQ(polQ), .senseQ(senseQ),
    .prioQ(prioQ), .destCpu(destCpu), .actQ(actQ), .lastQ(lastQ),
    .strobe(strobe), .newLast(newLast), .raiseReq(raiseReq)
  );
endmodule

// File: tb/isrc_bank_tb_top.sv
`timescale 1ns/1ps
module isrc_bank_tb_top;
  localparam int NS = 16;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic [NS-1:0] srcLevel, clrActive;
  logic        wrEn, wrSel;
  logic [3:0]  wrIdx, rdIdx;
  logic [31:0] wrData, rdCfg, rdDest;
  logic [NC*NS-1:0] raiseReq;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  isrc_bank #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_EXT(12)) dut_i (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .clrActive(clrActive),
    .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdCfg(rdCfg), .rdDest(rdDest), .raiseReq(raiseReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrIdx = 4'(idx); wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rdCfgOf(input int idx, output logic [31:0] v);
    rdIdx = 4'(idx); #1 v = rdCfg;
  endtask

  task automatic rdDestOf(input int idx, output logic [31:0] v);
    rdIdx = 4'(idx); #1 v = rdDest;
  endtask

  task automatic clrPulse(input int s);
    @(negedge clk); clrActive[s] = 1'b1;
    @(posedge clk); #1 clrActive[s] = 1'b0;
    @(negedge clk);
  endtask

  // retire activity, drop line one cycle, raise again, land after the raise edge
  task automatic pulse(input int s);
    @(negedge clk); clrActive[s] = 1'b1; srcLevel[s] = 1'b0;
    @(posedge clk); #1 clrActive[s] = 1'b0;
    @(negedge clk); srcLevel[s] = 1'b1;
    step(2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdCfgOf(0, v);  chk("R1 cfg", v, 32'hA000_0000);
    rdDestOf(0, v); chk("R1 dest", v, 32'h0);
    rdCfgOf(15, v); chk("R1 cfg15", v, 32'hA000_0000);
    chk("R1 raise", raiseReq, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(1'b0, 3, 32'hFFFF_FFFF);
    wr(1'b1, 3, 32'hFFFF_FFFF);
    wr(1'b0, 13, 32'hFFFF_FFFF);
    @(negedge clk);
    rdCfgOf(3, v);  chk("R2 cfg ext", v, 32'hA0CF_00FF);
    rdDestOf(3, v); chk("R2 dest", v, 32'hC000_0003);
    rdCfgOf(13, v); chk("R3 cfg int", v, 32'hA00F_00FF);
  endtask

  task automatic t_gating();
    logic [31:0] v;
    wr(1'b1, 1, 32'h1);
    wr(1'b0, 1, 32'h8045_0000);
    @(negedge clk); srcLevel[1] = 1'b1;
    step(3); chk("R4 masked", raiseReq, 32'h0);
    wr(1'b0, 1, 32'h0040_0000);
    step(3); chk("R4 prio0", raiseReq, 32'h0);
    wr(1'b1, 1, 32'hC000_0000);
    wr(1'b0, 1, 32'h0045_0000);
    step(3); chk("R4 no dest", raiseReq, 32'h0);
    rdCfgOf(1, v); chk("R4 inactive", v, 32'h0045_0000);
    rdDestOf(1, v); chk("R2 dest hi", v, 32'hC000_0000);
    srcLevel[1] = 1'b0;
  endtask

  task automatic t_levelDirected();
    logic [31:0] v;
    wr(1'b0, 2, 32'h0045_0022);
    wr(1'b1, 2, 32'h3);
    @(negedge clk); srcLevel[2] = 1'b1;
    step(1); chk("R12 not early", raiseReq, 32'h0);
    step(1); chk("R8 both cpus", raiseReq, (32'h1 << 2) | (32'h1 << 18));
    rdCfgOf(2, v); chk("R5 active", v, 32'h4045_0022);
    step(1); chk("R12 one cycle", raiseReq, 32'h0);
    step(3); chk("R7 held no repeat", raiseReq, 32'h0);
    srcLevel[2] = 1'b0;
    step(2); rdCfgOf(2, v); chk("R5 low clears", v, 32'h0045_0022);
    srcLevel[2] = 1'b1;
    step(2); chk("R5 re-raise", raiseReq, (32'h1 << 2) | (32'h1 << 18));
    srcLevel[2] = 1'b0;
    step(2);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    wr(1'b1, 4, 32'h1);
    wr(1'b0, 4, 32'h00C5_0000);
    step(1); chk("R5 active low", raiseReq, 32'h1 << 4);
    srcLevel[4] = 1'b1;
    step(2); rdCfgOf(4, v); chk("R5 inverted clear", v, 32'h00C5_0000);
    chk("R5 quiet", raiseReq, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(1'b1, 5, 32'h1);
    wr(1'b0, 5, 32'h0005_0000);
    @(negedge clk); srcLevel[5] = 1'b1;
    step(2); chk("R6 rise", raiseReq, 32'h1 << 5);
    rdCfgOf(5, v); chk("R11 act set", v, 32'h4005_0000);
    clrPulse(5);
    rdCfgOf(5, v); chk("R11 act cleared", v, 32'h0005_0000);
    step(3); chk("R6 held no re-raise", raiseReq, 32'h0);
    srcLevel[5] = 1'b0; step(1);
    srcLevel[5] = 1'b1; step(2);
    chk("R6 second rise", raiseReq, 32'h1 << 5);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(1'b0, 5, 32'hA0C9_0077);
    @(negedge clk); rdCfgOf(5, v); chk("R10 locked", v, 32'hC009_0077);
    clrPulse(5);
    wr(1'b0, 5, 32'h20C5_0011);
    @(negedge clk); rdCfgOf(5, v); chk("R10 unlocked", v, 32'h20C5_0011);
    step(2); chk("R10 quiet", raiseReq, 32'h0);
    wr(1'b0, 5, 32'h8000_0000);
  endtask

  task automatic t_distributed();
    wr(1'b1, 6, 32'h3);
    wr(1'b0, 6, 32'h2005_0000);
    pulse(6); chk("R9 first cpu1", raiseReq, 32'h1 << 22);
    pulse(6); chk("R9 then cpu0", raiseReq, 32'h1 << 6);
    pulse(6); chk("R9 then cpu1", raiseReq, 32'h1 << 22);
    wr(1'b1, 6, 32'h1);
    pulse(6); chk("R9 wrap to cpu0", raiseReq, 32'h1 << 6);
    pulse(6); chk("R8 only last cpu", raiseReq, 32'h1 << 6);
    wr(1'b1, 6, 32'h2);
    pulse(6); chk("R9 single other", raiseReq, 32'h1 << 22);
  endtask

  initial begin
    rstN = 1'b0; srcLevel = '0; clrActive = '0;
    wrEn = 1'b0; wrSel = 1'b0; wrIdx = '0; wrData = '0; rdIdx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_gating();
    t_levelDirected();
    t_polarity();
    t_edge();
    t_lock();
    t_distributed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule